// File: doc/BRIEF.md
# Low-Speed Serial Bus Packet Transmitter

This block puts one packet onto a differential low-speed serial bus pair. It runs at ten system clocks per bit time. On a start request it enables its line drivers and holds the idle (J) level for one bit time. It then shifts out a fixed sync byte of 0x80 followed by the payload bytes. Every byte goes out least significant bit first, with NRZI line coding and bit stuffing. The packet closes with an end-of-packet: two bit times of single-ended zero, one bit time of J, then the drivers are released.

Payload bytes arrive over a valid/ready stream. The block owns a one-byte holding slot. `in_ready` is high while that slot is empty and more payload bytes are still owed for the current packet, and a byte moves on any clock where `in_valid` and `in_ready` are both high. The source may hold back `in_valid` for as long as it likes, but a byte must be in the slot by the time the current byte's last bit time ends. If it is not, the line holds its level and the next bit waits until the byte arrives. The source must not drop `in_valid` once it has raised it until the transfer happens.

A data-packet qualifier, sampled with the start request, decides whether the pending device address on `new_addr` is copied into the active address output at end-of-packet. Handshake packets leave the active address alone.

Top module: `ls_pkt_tx`

## Requirements
- R1: During and right after reset, `oe`, `dp`, `dm`, `busy`, `done` and `in_ready` are 0 and `dev_addr` is 0.
- R2: `start` is acted on only when `busy` is low and `byte_cnt` (total bytes, sync included) lies in 2..12; any other `start` has no effect on the outputs.
- R3: In the clock after an accepted start, `oe` goes high with J driven (`dp`=0, `dm`=1) and stays there for 10 clocks. The sync byte 0x80 follows, least significant bit first.
- R4: Each bit occupies exactly 10 clocks. A 0 data bit swaps `dp` and `dm`, and a 1 data bit keeps them. Both lines are never high together.
- R5: Once six consecutive 1 bits have been sent, an extra toggled bit time is inserted and the run count restarts. The run is counted across byte boundaries, and it also applies after the final payload bit.
- R6: Exactly `byte_cnt`-1 payload bytes are accepted per packet, in send order. `in_ready` is high only while `busy`, the holding slot is empty and bytes are still owed.
- R7: After the last bit, both lines are driven low with `oe` high for 20 clocks, or 21 when an address commit happens. J is then driven for 10 clocks, after which `oe`, `dp` and `dm` all go low.
- R8: When `is_data` was 1 at the accepted start, `dev_addr` takes `new_addr` in the first single-ended-zero clock. Otherwise, and at every other time, `dev_addr` does not change.
- R9: `busy` is high from the clock after an accepted start until release. `done` is a one-clock pulse in the release clock, with `busy` and `oe` low.
- R10: While `oe` is low, `dp` and `dm` are both low (no pull-up level is driven).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, ten per bit time |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send one packet |
| byte_cnt | input | 4 | Total bytes including sync, sampled with start |
| is_data | input | 1 | Packet carries data; enables address commit |
| new_addr | input | 7 | Pending device address |
| in_valid | input | 1 | Payload byte present |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Holding slot free and bytes still owed |
| dp | output | 1 | Positive line value |
| dm | output | 1 | Negative line value |
| oe | output | 1 | Line driver enable for both lines |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-clock pulse at bus release |
| dev_addr | output | 7 | Active device address |

## Verification
On every clock the assertions watch the line-level invariants. These are: both lines low while undriven, no state with both lines high, J as the first driven level, and the release clock coinciding with the `done` pulse. They also check that the address changes only while both lines are low and driven, that `in_ready` never rises outside a packet, and how `busy` answers to valid and invalid starts. Bit timing, NRZI polarity, stuff insertion across byte boundaries and after the final bit, and the 20-versus-21 clock end-of-packet need whole packets. Only the bench's per-clock reference model can show those, run on sync-only-like, all-ones, tail-stuffing and full-length packets fed with irregular source gaps.

// File: rtl/ls_tx_pkg.sv
package ls_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_BITS,
    ST_SE0,
    ST_JEND
  } tx_state_e;
endpackage

// File: rtl/ls_tx_timer.sv
// Down-counter marking the end of each timed phase.
module ls_tx_timer #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - TW'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ls_tx_nrzi.sv
// Line level tracker with NRZI coding and run-of-ones stuffing.
module ls_tx_nrzi #(
  parameter int STUFF_RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic emit,
  input  logic emit_bit,
  input  logic stuff,
  output logic level,      // 1 = J, 0 = K
  output logic stuff_due
);
  localparam int OW = $clog2(STUFF_RUN + 1);
  logic [OW-1:0] ones;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= 1'b1;
      ones  <= '0;
    end else if (init) begin
      level <= 1'b1;
      ones  <= '0;
    end else if (stuff) begin
      level <= ~level;
      ones  <= '0;
    end else if (emit) begin
      if (emit_bit) begin
        ones <= ones + OW'(1);
      end else begin
        level <= ~level;
        ones  <= '0;
      end
    end
  end

  assign stuff_due = (ones == OW'(STUFF_RUN));
endmodule

// File: rtl/ls_tx_fetch.sv
// One-byte holding slot fed by a valid/ready stream.
module ls_tx_fetch #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [CW-1:0] arm_cnt,
  input  logic          take,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          full,
  output logic [7:0]    data
);
  logic [CW-1:0] owed;
  logic          accept;

  assign in_ready = !full && (owed != '0);
  assign accept   = in_ready && in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed <= '0;
      full <= 1'b0;
      data <= '0;
    end else if (arm) begin
      owed <= arm_cnt;
      full <= 1'b0;
    end else begin
      if (accept) begin
        owed <= owed - CW'(1);
        data <= in_data;
      end
      if (take)        full <= 1'b0;
      else if (accept) full <= 1'b1;
    end
  end
endmodule

// File: rtl/ls_pkt_tx.sv
module ls_pkt_tx
  import ls_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 10,
  parameter int MIN_BYTES    = 2,
  parameter int MAX_BYTES    = 12,
  parameter int ADDR_W       = 7,
  parameter int STUFF_RUN    = 6,
  parameter logic [7:0] SYNC_BYTE = 8'h80,
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CW-1:0]     byte_cnt,
  input  logic              is_data,
  input  logic [ADDR_W-1:0] new_addr,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              dp,
  output logic              dm,
  output logic              oe,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] dev_addr
);
  localparam int TW     = $clog2(2 * CLKS_PER_BIT + 2);
  localparam int BIT_LD = CLKS_PER_BIT - 1;
  localparam int SE0_LD = 2 * CLKS_PER_BIT - 1;

  tx_state_e     state;
  logic [7:0]    shift;
  logic [2:0]    bit_idx;
  logic [CW-1:0] left;
  logic          data_q;

  logic          tick, count_ok, accept;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          nz_init, nz_emit, nz_bit, nz_stuff, level, stuff_due;
  logic          take, hold_full;
  logic [7:0]    hold_data;
  logic          go_byte, go_next, go_eop;

  assign count_ok = (byte_cnt >= CW'(MIN_BYTES)) && (byte_cnt <= CW'(MAX_BYTES));
  assign accept   = (state == ST_IDLE) && start && count_ok;

  ls_tx_timer #(.TW(TW)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tick)
  );

  ls_tx_nrzi #(.STUFF_RUN(STUFF_RUN)) i_nrzi (
    .clk(clk), .rst_n(rst_n), .init(nz_init), .emit(nz_emit), .emit_bit(nz_bit),
    .stuff(nz_stuff), .level(level), .stuff_due(stuff_due)
  );

  ls_tx_fetch #(.CW(CW)) i_fetch (
    .clk(clk), .rst_n(rst_n), .arm(accept), .arm_cnt(byte_cnt - CW'(1)), .take(take),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .full(hold_full), .data(hold_data)
  );

  // Bit boundary decisions inside the packet body.
  always_comb begin
    go_next = 1'b0;
    go_eop  = 1'b0;
    go_byte = 1'b0;
    if (state == ST_BITS && tick && !stuff_due) begin
      if (bit_idx != 3'd7)    go_next = 1'b1;
      else if (left == '0)    go_eop  = 1'b1;
      else if (hold_full)     go_byte = 1'b1;
    end
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TW'(BIT_LD);
    nz_init  = 1'b0;
    nz_emit  = 1'b0;
    nz_bit   = 1'b0;
    nz_stuff = 1'b0;
    take     = go_byte;
    unique case (state)
      ST_IDLE: begin
        tmr_load = accept;
        nz_init  = accept;
      end
      ST_PREP: begin
        tmr_load = tick;
        nz_emit  = tick;
        nz_bit   = shift[0];
      end
      ST_BITS: begin
        nz_stuff = tick && stuff_due;
        nz_emit  = go_next || go_byte;
        nz_bit   = go_byte ? hold_data[0] : shift[1];
        tmr_load = nz_stuff || nz_emit || go_eop;
        if (go_eop) tmr_val = TW'(SE0_LD) + TW'(data_q);
      end
      ST_SE0:  tmr_load = tick;
      ST_JEND: tmr_load = 1'b0;
      default: tmr_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shift    <= '0;
      bit_idx  <= '0;
      left     <= '0;
      data_q   <= 1'b0;
      done     <= 1'b0;
      dev_addr <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_PREP;
          shift   <= SYNC_BYTE;
          bit_idx <= '0;
          left    <= byte_cnt - CW'(1);
          data_q  <= is_data;
        end
        ST_PREP: if (tick) state <= ST_BITS;
        ST_BITS: begin
          if (go_next) begin
            shift   <= shift >> 1;
            bit_idx <= bit_idx + 3'd1;
          end else if (go_byte) begin
            shift   <= hold_data;
            bit_idx <= '0;
            left    <= left - CW'(1);
          end else if (go_eop) begin
            state <= ST_SE0;
            if (data_q) dev_addr <= new_addr;
          end
        end
        ST_SE0:  if (tick) state <= ST_JEND;
        ST_JEND: if (tick) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign oe   = busy;
  assign dp   = (state == ST_BITS) && !level;
  assign dm   = (state == ST_PREP) || (state == ST_JEND) || ((state == ST_BITS) && level);
endmodule

// File: rtl/ls_pkt_tx_chk.sv
module ls_pkt_tx_chk #(
  parameter int MIN_BYTES = 2,
  parameter int MAX_BYTES = 12,
  parameter int CW        = 4,
  parameter int ADDR_W    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CW-1:0]     byte_cnt,
  input logic              in_ready,
  input logic              dp,
  input logic              dm,
  input logic              oe,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] dev_addr
);
  logic cnt_ok;
  assign cnt_ok = (byte_cnt >= CW'(MIN_BYTES)) && (byte_cnt <= CW'(MAX_BYTES));

  p_take_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cnt_ok) |=> busy);
  p_refuse_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !cnt_ok) |=> !busy);
  p_j_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> (dm && !dp));
  p_no_se1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> !(dp && dm));
  p_ready_in_pkt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> done);
  p_addr_in_se0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_addr != $past(dev_addr)) |-> (oe && !dp && !dm));
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !oe));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_quiet_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!dp && !dm));
endmodule

bind ls_pkt_tx ls_pkt_tx_chk #(
  .MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES), .CW(CW), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt), .in_ready(in_ready),
  .dp(dp), .dm(dm), .oe(oe), .busy(busy), .done(done), .dev_addr(dev_addr)
);

// File: tb/test_ls_pkt_tx.sv
`timescale 1ns/100ps
module test_ls_pkt_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] byte_cnt = '0;
  logic       is_data = 1'b0;
  logic [6:0] new_addr = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, dp, dm, oe, busy, done;
  logic [6:0] dev_addr;

  ls_pkt_tx i_ls_pkt_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt), .is_data(is_data),
    .new_addr(new_addr), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .dp(dp), .dm(dm), .oe(oe), .busy(busy), .done(done), .dev_addr(dev_addr)
  );

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0, cycles = 0, accepted = 0;
  bit running = 1'b0;
  logic [11:0] exp_q[$];  // {addr, oe, dp, dm, busy, done}
  string       tag_q[$];
  logic [7:0]  feed_q[$];
  logic [6:0]  addr_m = '0;

  task automatic fail(input string req, input string what, input int act, input int exp);
    miscompares++;
    $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) fail(req, what, act, exp);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // Per-clock comparison against the reference model.
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fail("R9", "watchdog busy", busy, 0);
      finish_run();
    end
    if (running) begin
      logic [11:0] e;
      string t;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
      end else begin
        e = {addr_m, 5'b00000};
        t = "R10";
      end
      vectors++;
      if (dev_addr != e[11:5]) fail("R8", "dev_addr", dev_addr, e[11:5]);
      else if ({oe, dp, dm, busy, done} != e[4:0]) fail(t, "oe,dp,dm,busy,done", {oe, dp, dm, busy, done}, e[4:0]);
    end
  end

  // Payload source with irregular gaps.
  int gap = 3, seed = 1;
  bit took = 1'b0;
  always @(negedge clk) begin
    #2;
    if (took) begin
      void'(feed_q.pop_front());
      in_valid = 1'b0;
      accepted++;
      seed = (seed * 7 + 3) % 31;
      gap = seed % 25;
    end
    if (!in_valid && feed_q.size() > 0) begin
      if (gap > 0) gap--;
      else begin
        in_valid = 1'b1;
        in_data  = feed_q[0];
      end
    end
    took = in_valid && in_ready;
  end

  task automatic push_n(input int n, input logic [4:0] lines, input string t);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back({addr_m, lines});
      tag_q.push_back(t);
    end
  endtask

  // Build expected per-clock outputs for one packet and launch it.
  task automatic run_pkt(input logic dat, input logic [6:0] na, input logic [7:0] body[$]);
    logic lvl;
    int ones;
    logic [7:0] all[$];
    int n;
    all = body;
    all.push_front(8'h80);
    n = all.size();
    @(negedge clk); #1;
    lvl = 1'b1; ones = 0;
    push_n(10, 5'b10110, "R3");
    foreach (all[bi]) begin
      for (int i = 0; i < 8; i++) begin
        if (all[bi][i]) ones++;
        else begin lvl = !lvl; ones = 0; end
        push_n(10, {1'b1, !lvl, lvl, 2'b10}, "R4");
        if (ones == 6) begin
          lvl = !lvl; ones = 0;
          push_n(10, {1'b1, !lvl, lvl, 2'b10}, "R5");
        end
      end
    end
    if (dat) addr_m = na;
    push_n(dat ? 21 : 20, 5'b10010, "R7");
    push_n(10, 5'b10110, "R7");
    push_n(1, 5'b00001, "R9");
    foreach (body[j]) feed_q.push_back(body[j]);
    accepted = 0;
    new_addr = na;
    is_data  = dat;
    byte_cnt = 4'(n);
    start    = 1'b1;
    @(negedge clk); #1;
    start    = 1'b0;
    byte_cnt = 4'd5;   // changed after acceptance: must not matter
    is_data  = !dat;
    while (exp_q.size() > 0) @(negedge clk);
    #1;
    is_data = dat;
    check("R6", "bytes accepted", accepted, n - 1);
    check("R6", "in_ready after packet", in_ready, 0);
  endtask

  task automatic try_reject(input logic [3:0] c);
    @(negedge clk); #1;
    byte_cnt = c; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    repeat (15) @(negedge clk);
    #1;
    check("R2", "busy after refused start", busy, 0);
  endtask

  initial begin
    logic [7:0] b[$];
    repeat (3) @(negedge clk);
    check("R1", "oe in reset", oe, 0);
    check("R1", "dp/dm in reset", {dp, dm}, 0);
    check("R1", "busy/done in reset", {busy, done}, 0);
    check("R1", "in_ready in reset", in_ready, 0);
    check("R1", "dev_addr in reset", dev_addr, 0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    running = 1'b1;
    repeat (5) @(negedge clk);

    // Handshake packet: no address commit (R8), 20-clock SE0 (R7).
    b = '{8'hD2};
    run_pkt(1'b0, 7'h15, b);
    check("R8", "address kept after handshake", dev_addr, 0);

    // Data packet with commit.
    b = '{8'hC3, 8'h00, 8'h5A};
    run_pkt(1'b1, 7'h2A, b);
    check("R8", "address committed", dev_addr, 7'h2A);

    // All ones: stuffing inside and across bytes (R5).
    b = '{8'hFF, 8'hFF, 8'hFF};
    run_pkt(1'b0, 7'h01, b);

    // Six ones ending the final byte: stuff before end-of-packet (R5).
    b = '{8'hFC};
    run_pkt(1'b1, 7'h33, b);

    // Refused starts (R2).
    try_reject(4'd1);
    try_reject(4'd13);
    try_reject(4'd0);

    // Full-length packet; a stray start in the middle must be ignored (R2).
    b = '{8'h01, 8'h7E, 8'hFE, 8'h80, 8'hA5, 8'h3F, 8'hF0, 8'h0F, 8'hFF, 8'h55, 8'h7F};
    fork
      run_pkt(1'b1, 7'h7F, b);
      begin
        repeat (200) @(negedge clk);
        #1;
        byte_cnt = 4'd3; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
      end
    join
    check("R8", "address after long packet", dev_addr, 7'h7F);
    repeat (10) @(negedge clk);
    running = 1'b0;
    finish_run();
  end
endmodule